// File: doc/BRIEF.md
# Dual-Edge Differential Pixel Data Sampler

This block sits behind a bank of differential line receivers on a column driver. Each of the six receivers delivers one single-ended bit stream, and each stream carries two bits in every clock period. The first bit is taken on the falling edge of the differential clock. The second bit is taken on the rising edge that follows. The block pairs the two half-period samples of every lane and presents one 12-bit word per clock period, one bit for each of the twelve shift-register chains. A one-period valid strobe tells the shift register when to advance.

Two inputs gate the block. An interface select decides whether the differential path is in use at all. A capture enable decides, at each falling edge, whether a new word begins. When capture is enabled, words start at the first falling edge that sees the enable high. When capture is disabled, a word that has already started is still completed, and no new word begins. If the differential path is deselected between the two halves of a word, that partial word is dropped.

Top module: `rsds_dual_edge_sampler`

## Requirements
- R1: While `rst_n` is low, `word_vld_o` is 0 and `word_o` is all zeros.
- R2: While `if_sel` is 0, no word is produced: `word_vld_o` stays 0 after every rising edge of `dclk`.
- R3: A falling edge of `dclk` at which `cap_en` is 0 starts no word, so `word_vld_o` is 0 after the following rising edge.
- R4: Once `cap_en` is high, the first word begins at the first falling edge of `dclk` that samples `cap_en` high. Its `word_vld_o` pulse follows the next rising edge.
- R5: Lane p (0 to 5) supplies two bits of the word. The bit sampled on the falling edge goes to `word_o[2p]`, and the bit sampled on the following rising edge goes to `word_o[2p+1]`.
- R6: Every complete falling-then-rising pair raises `word_vld_o` for exactly the one period after that rising edge. Back-to-back pairs keep it high in every period, with a new word each period.
- R7: `cap_en` is looked at only on falling edges. A word whose falling half saw `cap_en` high completes even if `cap_en` is already low at the following rising edge.
- R8: If `if_sel` is 0 at the rising edge that would complete a word, the half-captured bits are discarded and no valid pulse follows.
- R9: Whenever `word_vld_o` is 0, `word_o` keeps the last completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Differential clock after conversion; both edges sample data |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_sel | input | 1 | 1 selects the differential interface; 0 blocks all output |
| cap_en | input | 1 | Capture enable, checked on each falling edge of `dclk` |
| pair_bits | input | 6 | One single-ended bit per differential lane, lane 0 in bit 0 |
| word_o | output | 12 | Assembled word; bit k feeds chain k+1 |
| word_vld_o | output | 1 | One-period strobe for each completed word |

## Verification
The bench targets the following corner cases, and shows what a wrong design would do in each:
- **Lane order.** Walking-one patterns on each lane and each edge expose a design that swaps the falling and rising bits, or that places a lane in the wrong pair of word bits.
- **Start of capture.** The first word after `cap_en` rises must be the one whose falling half saw the enable. A design that waits for a rising edge would shift every bit by half a period.
- **End of capture.** When the enable falls between the halves, the word must still complete, and nothing may follow it. A design that checks the enable on the rising edge would lose that last word.
- **Deselect mid-word.** When `if_sel` drops mid-word, the partial word must be discarded and `word_o` left unchanged. A design that ignores this would emit a word built from stale bits.

// File: rtl/rsds_pkg.sv
package rsds_pkg;

  localparam int DEF_PAIRS = 6;

  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } phase_e;

  // Word bit position of a lane's half-period sample.
  function automatic int chain_index(input int lane, input int phase);
    return 2 * lane + phase;
  endfunction

endpackage

// File: rtl/rsds_fall_capture.sv
module rsds_fall_capture
  import rsds_pkg::*;
#(
  parameter int NUM_PAIRS = DEF_PAIRS
) (
  input  logic                 dclk,
  input  logic                 rst_n,
  input  logic                 if_sel,
  input  logic                 cap_en,
  input  logic [NUM_PAIRS-1:0] pair_bits,
  output logic [NUM_PAIRS-1:0] fall_bits,
  output logic                 half_ready
);

  logic take_fall;
  assign take_fall = if_sel & cap_en;

  always_ff @(negedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      fall_bits  <= '0;
      half_ready <= 1'b0;
    end else begin
      half_ready <= take_fall;
      if (take_fall) fall_bits <= pair_bits;
    end
  end

  // R3
  no_start_without_enable_chk: assert property (
    @(negedge dclk) disable iff (!rst_n)
    !cap_en |=> !half_ready
  );

  // R2
  no_start_when_deselected_chk: assert property (
    @(negedge dclk) disable iff (!rst_n)
    !if_sel |=> !half_ready
  );

endmodule

// File: rtl/rsds_rise_combine.sv
module rsds_rise_combine
  import rsds_pkg::*;
#(
  parameter int NUM_PAIRS = DEF_PAIRS,
  localparam int WORD_W = 2 * NUM_PAIRS
) (
  input  logic                 dclk,
  input  logic                 rst_n,
  input  logic                 if_sel,
  input  logic                 half_ready,
  input  logic [NUM_PAIRS-1:0] fall_bits,
  input  logic [NUM_PAIRS-1:0] pair_bits,
  output logic [WORD_W-1:0]    word_o,
  output logic                 word_vld_o,
  output logic                 word_done
);

  logic [WORD_W-1:0] merged;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_lane
    assign merged[chain_index(p, int'(PH_FALL))] = fall_bits[p];
    assign merged[chain_index(p, int'(PH_RISE))] = pair_bits[p];
  end

  assign word_done = half_ready & if_sel;

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= word_done;
      if (word_done) word_o <= merged;
    end
  end

  // R2
  idle_when_deselected_chk: assert property (
    @(posedge dclk) disable iff (!rst_n)
    !if_sel |=> !word_vld_o
  );

  // R3
  no_word_without_half_chk: assert property (
    @(posedge dclk) disable iff (!rst_n)
    !half_ready |=> !word_vld_o
  );

  // R6
  complete_pair_strobes_chk: assert property (
    @(posedge dclk) disable iff (!rst_n)
    (half_ready && if_sel) |=> word_vld_o
  );

  // R9
  word_held_when_idle_chk: assert property (
    @(posedge dclk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o)
  );

endmodule

// File: rtl/rsds_dual_edge_sampler.sv
module rsds_dual_edge_sampler
  import rsds_pkg::*;
#(
  parameter int NUM_PAIRS = DEF_PAIRS,
  localparam int WORD_W = 2 * NUM_PAIRS
) (
  input  logic                 dclk,
  input  logic                 rst_n,
  input  logic                 if_sel,
  input  logic                 cap_en,
  input  logic [NUM_PAIRS-1:0] pair_bits,
  output logic [WORD_W-1:0]    word_o,
  output logic                 word_vld_o
);

  logic [NUM_PAIRS-1:0] fall_bits;
  logic                 half_ready;
  logic                 word_done;

  rsds_fall_capture #(.NUM_PAIRS(NUM_PAIRS)) u_fall (
    .dclk       (dclk),
    .rst_n      (rst_n),
    .if_sel     (if_sel),
    .cap_en     (cap_en),
    .pair_bits  (pair_bits),
    .fall_bits  (fall_bits),
    .half_ready (half_ready)
  );

  rsds_rise_combine #(.NUM_PAIRS(NUM_PAIRS)) u_rise (
    .dclk       (dclk),
    .rst_n      (rst_n),
    .if_sel     (if_sel),
    .half_ready (half_ready),
    .fall_bits  (fall_bits),
    .pair_bits  (pair_bits),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .word_done  (word_done)
  );

  // R1
  reset_quiet_chk: assert property (
    @(posedge dclk) !rst_n |-> (!word_vld_o && word_o == '0)
  );

  // R6
  strobe_tracks_done_chk: assert property (
    @(posedge dclk) disable iff (!rst_n)
    !word_done |=> !word_vld_o
  );

endmodule

// File: tb/rsds_dual_edge_sampler_test.sv
module rsds_dual_edge_sampler_test;

  logic        dclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_sel = 1'b0;
  logic        cap_en = 1'b0;
  logic [5:0]  pair_bits = '0;
  logic [11:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [11:0] exp_word = '0;
  bit          exp_vld = 0;

  rsds_dual_edge_sampler uut (
    .dclk       (dclk),
    .rst_n      (rst_n),
    .if_sel     (if_sel),
    .cap_en     (cap_en),
    .pair_bits  (pair_bits),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  always #2.5 dclk = ~dclk;

  task automatic compare(input string tag);
    string wtag;
    checks++;
    if (word_vld_o !== exp_vld) begin
      failures++;
      $display("FAIL %s valid: actual=%0b expected=%0b", tag, word_vld_o, exp_vld);
    end
    wtag = exp_vld ? tag : {tag, "/R9"};
    checks++;
    if (word_o !== exp_word) begin
      failures++;
      $display("FAIL %s word: actual=%03h expected=%03h", wtag, word_o, exp_word);
    end
  endtask

  // One clock period: falling half then rising half, checked after the rising edge.
  task automatic period(input string tag, input bit sel_f, input bit en_f,
                        input logic [5:0] fb, input bit sel_r, input bit en_r,
                        input logic [5:0] rb);
    bit pend;
    logic [5:0] held;
    if_sel = sel_f; cap_en = en_f; pair_bits = fb;
    @(negedge dclk);
    pend = sel_f && en_f;
    held = fb;
    #1;
    if_sel = sel_r; cap_en = en_r; pair_bits = rb;
    @(posedge dclk);
    if (pend && sel_r) begin
      exp_vld = 1;
      for (int k = 0; k < 12; k++)
        exp_word[k] = (k % 2 == 1) ? rb[k / 2] : held[k / 2];
    end else begin
      exp_vld = 0;
    end
    #2;
    compare(tag);
  endtask

  initial begin
    // R1: outputs quiet during reset
    #12;
    compare("R1");
    @(posedge dclk); #1 rst_n = 1'b1;
    @(posedge dclk); #2;
    compare("R1");

    // R2: interface deselected
    for (int i = 0; i < 3; i++) period("R2", 0, 1, 6'h3F, 0, 1, 6'h3F);
    // R3: enable low
    for (int i = 0; i < 3; i++) period("R3", 1, 0, 6'h2A, 1, 0, 6'h15);
    // R4: first word after enable rises
    period("R4", 1, 1, 6'h2A, 1, 1, 6'h15);
    // R5: walking ones on each lane and each half
    for (int p = 0; p < 6; p++) begin
      period("R5", 1, 1, 6'(1 << p), 1, 1, 6'h00);
      period("R5", 1, 1, 6'h00, 1, 1, 6'(1 << p));
    end
    // R6: back-to-back stream
    for (int i = 0; i < 20; i++)
      period("R6", 1, 1, 6'((i * 13 + 5) & 63), 1, 1, 6'((i * 29 + 11) & 63));
    // R7: enable drops between halves; the word still completes, then stops
    period("R7", 1, 1, 6'h31, 1, 0, 6'h0E);
    period("R7", 1, 0, 6'h3F, 1, 0, 6'h3F);
    period("R7", 1, 0, 6'h00, 1, 0, 6'h00);
    // R8: deselect between halves discards the partial word
    period("R8", 1, 1, 6'h3F, 0, 1, 6'h3F);
    period("R8", 0, 1, 6'h12, 1, 1, 6'h21);
    period("R6", 1, 1, 6'h07, 1, 1, 6'h38);
    period("R8", 1, 1, 6'h15, 0, 1, 6'h2A);
    period("R4", 1, 1, 6'h0C, 1, 1, 6'h33);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule